// File: doc/BRIEF.md
# PCM Frame Time-Slot Port

This block is the serial voice-data port of a telephony codec. A bit clock and an 8 kHz frame sync arrive from the system. In each frame the block sends one transmit word on a tristate-capable output and captures one receive word from the serial input, both inside a single assigned time slot. Both external clocks are oversampled by a faster fabric clock, so all state lives in one synchronous domain. Rising and falling bit-clock edges are found by edge detection.

The slot position depends on several settings. A timing-mode field sets how the frame sync relates to the first bit and which bit-clock edges launch and sample data. A format bit chooses between two channel layouts. A slot bit picks the first or second channel, but only in 8-bit companded operation. In 14-bit linear operation a single 16-bit slot starts at the frame start. The block also has a transfer enable and a power-up gate that keeps the output undriven for the first frame. It can put a byte loaded from the control side in place of the transmit sample for one frame. The last received word is held for the control side to read.

Top module: `pcm_slot_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dx_oe` is 0, `rx_valid` is 0 and `rx_pcm` is 0.
- R2: When `cfg_mode` is 2'b00 (non-delayed normal), a frame begins at the bit-clock rising edge where `fs` is first seen high after being low at the previous rising edge. Bit period k of the frame starts at the k-th rising edge after that one. Each slot bit is launched on the rising edge that starts its period and is sampled on the falling edge inside that period. Bits go out and come in MSB first.
- R3: When `cfg_mode` is 2'b01 (non-delayed reverse), frame start is found as in R2. Each slot bit is launched on the falling edge inside its period and is sampled on the rising edge that ends the period.
- R4: When `cfg_mode[1]` is 1 (delayed), `fs` is sampled on falling bit-clock edges. A frame begins at the first rising edge after a falling-edge sample that reads high following one that read low. Edges are used as in R2.
- R5: With `cfg_comp`=1, the first channel occupies bit periods 0..7. With `cfg_b2`=1 the slot moves to the second channel: periods 8..15 when `cfg_fmt2`=0, and periods 10..17 when `cfg_fmt2`=1, which leaves a two-period gap.
- R6: With `cfg_comp`=0, the slot is periods 0..15 whatever `cfg_b2` and `cfg_fmt2` are. It carries `tx_pcm[13:0]` MSB first and then two 0 bits. `rx_pcm` takes the first 14 received bits, and the last two are dropped.
- R7: `dx_oe` is 1 only during slot bit periods; `dx_d` is 0 whenever `dx_oe` is 0. With `cfg_en`=0 there is no drive, no capture, no `rx_valid` pulse, and `rx_pcm` keeps its value.
- R8: After `pwr_up` rises, `dx_oe` stays 0 through the whole first frame. Driving begins in the frame started by the second frame sync. Reception works from the first frame.
- R9: In companded mode, a pulse on `inj_load` stores `inj_data`. That byte is sent in place of `tx_pcm[7:0]` in the next frame only, and the frame after it sends `tx_pcm` again.
- R10: `rx_valid` pulses for one cycle when the last slot bit is captured. `rx_pcm` changes only in that cycle. In companded mode `rx_pcm` is the received byte with its upper six bits 0.
- R11: Only a low-to-high change of `fs` starts a frame. A one-period sync pulse works. A sync held high across a frame boundary starts nothing new, so that frame has no drive and no capture.
- R12: While `pwr_up` is 0, no frame starts, `dx_oe` is 0 from the next cycle on, and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Serial bit clock (asynchronous, oversampled) |
| fs | input | 1 | Frame sync, 8 kHz |
| dr | input | 1 | Serial receive data |
| cfg_mode | input | 2 | 00 non-delayed normal, 01 non-delayed reverse, 1x delayed |
| cfg_fmt2 | input | 1 | 1 selects the layout with the two-period gap |
| cfg_b2 | input | 1 | 1 selects the second channel (companded only) |
| cfg_comp | input | 1 | 1 companded 8-bit, 0 linear 14-bit |
| cfg_en | input | 1 | Transfer enable |
| pwr_up | input | 1 | Powered-up level |
| tx_pcm | input | 14 | Transmit sample (companded uses bits 7:0) |
| inj_data | input | 8 | Byte from the control side |
| inj_load | input | 1 | One-cycle strobe storing `inj_data` |
| dx_d | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Output enable for the transmit pin |
| rx_pcm | output | 14 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_pcm` updates |

## Verification
The main path is driven with a full frame of bit clock and a different receive pattern each time. The tests cover both channels in both layouts, the reverse and delayed timing modes, and linear mode with the slot and format bits set so that ignoring them shows. The transmit enable is compared per bit period, which tells a slot shifted by one period apart from the right one and a half-period edge error apart from a correct launch. The receive word tells whether sampling happened on the right edge and at the right offset. Further frames separate the first and second frame after power-up, a one-off injected byte from a sticky one, and a sync held high from a new edge.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;
  localparam int unsigned POS_W    = 6;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = 14;
  localparam int unsigned LIN_BITS = 16;
  localparam int unsigned GAP_BITS = 2;

  typedef logic [POS_W-1:0] pos_t;
  localparam pos_t POS_IDLE = '1;

  // first bit period of the assigned slot
  function automatic pos_t slot_first(input logic comp, input logic fmt2, input logic b2);
    if (!comp || !b2) return '0;
    return fmt2 ? pos_t'(BYTE_W + GAP_BITS) : pos_t'(BYTE_W);
  endfunction

  function automatic pos_t slot_bits(input logic comp);
    return comp ? pos_t'(BYTE_W) : pos_t'(LIN_BITS);
  endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk,
  input  logic fs,
  input  logic dr,
  output logic mclk_rise,
  output logic mclk_fall,
  output logic fs_s,
  output logic dr_s
);
  logic [STAGES-1:0] m_sync, f_sync, d_sync;
  logic m_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_sync <= '0;
      f_sync <= '0;
      d_sync <= '0;
      m_last <= 1'b0;
    end else begin
      m_sync <= {m_sync[STAGES-2:0], mclk};
      f_sync <= {f_sync[STAGES-2:0], fs};
      d_sync <= {d_sync[STAGES-2:0], dr};
      m_last <= m_sync[STAGES-1];
    end
  end

  assign mclk_rise = m_sync[STAGES-1] & ~m_last;
  assign mclk_fall = ~m_sync[STAGES-1] & m_last;
  assign fs_s      = f_sync[STAGES-1];
  assign dr_s      = d_sync[STAGES-1];
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_tsi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mclk_rise,
  input  logic mclk_fall,
  input  logic fs_s,
  input  logic delayed,
  input  logic pwr_up,
  output pos_t pos,
  output pos_t pos_nxt,
  output logic start,
  output logic gate_nxt
);
  localparam logic [1:0] OPEN_CNT = 2'd2;

  logic       fs_at_rise, fs_at_fall, fs_at_fall_prev;
  logic [1:0] sync_cnt, sync_cnt_nxt;
  logic       edge_seen;

  always_comb begin
    edge_seen = delayed ? (fs_at_fall & ~fs_at_fall_prev) : (fs_s & ~fs_at_rise);
    start     = mclk_rise & edge_seen & pwr_up;
    if (start)                             pos_nxt = '0;
    else if (mclk_rise && pos != POS_IDLE) pos_nxt = pos + 1'b1;
    else                                   pos_nxt = pos;
    if (!pwr_up)                              sync_cnt_nxt = '0;
    else if (start && sync_cnt != OPEN_CNT)   sync_cnt_nxt = sync_cnt + 1'b1;
    else                                      sync_cnt_nxt = sync_cnt;
    gate_nxt = pwr_up && (sync_cnt_nxt == OPEN_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos             <= POS_IDLE;
      sync_cnt        <= '0;
      fs_at_rise      <= 1'b0;
      fs_at_fall      <= 1'b0;
      fs_at_fall_prev <= 1'b0;
    end else begin
      pos      <= pos_nxt;
      sync_cnt <= sync_cnt_nxt;
      if (mclk_rise) fs_at_rise <= fs_s;
      if (mclk_fall) begin
        fs_at_fall_prev <= fs_at_fall;
        fs_at_fall      <= fs_s;
      end
    end
  end

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mclk_rise && !start && pos != POS_IDLE) |=> (pos == $past(pos) + 1'b1));
  // R11
  start_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (pos == '0));
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter
  import pcm_tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mclk_rise,
  input  logic              mclk_fall,
  input  logic              dr_s,
  input  logic              reverse,
  input  logic              comp,
  input  logic              fmt2,
  input  logic              b2,
  input  logic              en,
  input  logic              pwr_up,
  input  pos_t              pos,
  input  pos_t              pos_nxt,
  input  logic              start,
  input  logic              gate_nxt,
  input  logic [WORD_W-1:0] tx_pcm,
  input  logic [BYTE_W-1:0] inj_data,
  input  logic              inj_load,
  output logic              dx_d,
  output logic              dx_oe,
  output logic [WORD_W-1:0] rx_pcm,
  output logic              rx_valid
);
  localparam int unsigned IDX_W = $clog2(LIN_BITS);

  logic [LIN_BITS-1:0] tx_word, new_word, tx_cur, rx_sh, rx_full;
  logic [BYTE_W-1:0]   inj_q;
  logic                inj_pend;
  pos_t                lo, len, lpos, l_off, c_off;
  logic                launch, capture, l_in, c_in, c_last, l_bit;
  logic [IDX_W-1:0]    l_idx;

  always_comb begin
    lo       = slot_first(comp, fmt2, b2);
    len      = slot_bits(comp);
    new_word = comp ? {(inj_pend ? inj_q : tx_pcm[BYTE_W-1:0]), {(LIN_BITS-BYTE_W){1'b0}}}
                    : {tx_pcm, {(LIN_BITS-WORD_W){1'b0}}};
    tx_cur   = start ? new_word : tx_word;
    launch   = reverse ? mclk_fall : mclk_rise;
    capture  = reverse ? mclk_rise : mclk_fall;
    lpos     = reverse ? pos : pos_nxt;
    l_in     = (lpos != POS_IDLE) && (lpos >= lo) && (lpos < lo + len);
    c_in     = (pos != POS_IDLE) && (pos >= lo) && (pos < lo + len);
    l_off    = lpos - lo;
    c_off    = pos - lo;
    l_idx    = IDX_W'(l_off);
    l_bit    = tx_cur[IDX_W'(LIN_BITS-1) - l_idx];
    c_last   = (c_off == len - 1'b1);
    rx_full  = {rx_sh[LIN_BITS-2:0], dr_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word  <= '0;
      inj_q    <= '0;
      inj_pend <= 1'b0;
      rx_sh    <= '0;
      rx_pcm   <= '0;
      rx_valid <= 1'b0;
      dx_d     <= 1'b0;
      dx_oe    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start) begin
        tx_word <= new_word;
        if (comp) inj_pend <= 1'b0;
      end
      if (inj_load) begin
        inj_pend <= 1'b1;
        inj_q    <= inj_data;
      end
      if (!en || !pwr_up) begin
        dx_oe <= 1'b0;
        dx_d  <= 1'b0;
      end else if (launch) begin
        dx_oe <= l_in & gate_nxt;
        dx_d  <= l_in & gate_nxt & l_bit;
      end
      if (capture && en && pwr_up && c_in) begin
        rx_sh <= rx_full;
        if (c_last) begin
          rx_valid <= 1'b1;
          rx_pcm   <= comp ? {{(WORD_W-BYTE_W){1'b0}}, rx_full[BYTE_W-1:0]}
                           : rx_full[LIN_BITS-1:LIN_BITS-WORD_W];
        end
      end
    end
  end

  // R7
  oe_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dx_oe) |-> ($past(en) && $past(pwr_up)));
  // R7
  quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
    !dx_oe |-> !dx_d);
  // R12
  off_when_down_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_up |=> !dx_oe);
  // R10
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_pcm) |-> rx_valid);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_tsi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclk,
  input  logic              fs,
  input  logic              dr,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_fmt2,
  input  logic              cfg_b2,
  input  logic              cfg_comp,
  input  logic              cfg_en,
  input  logic              pwr_up,
  input  logic [WORD_W-1:0] tx_pcm,
  input  logic [BYTE_W-1:0] inj_data,
  input  logic              inj_load,
  output logic              dx_d,
  output logic              dx_oe,
  output logic [WORD_W-1:0] rx_pcm,
  output logic              rx_valid
);
  logic mclk_rise, mclk_fall, fs_s, dr_s, start, gate_nxt;
  pos_t pos, pos_nxt;
  logic delayed, reverse;

  assign delayed = cfg_mode[1];
  assign reverse = (cfg_mode == 2'b01);

  pcm_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .mclk(mclk), .fs(fs), .dr(dr),
    .mclk_rise(mclk_rise), .mclk_fall(mclk_fall), .fs_s(fs_s), .dr_s(dr_s)
  );

  pcm_frame_timer i_timer (
    .clk(clk), .rst(rst), .mclk_rise(mclk_rise), .mclk_fall(mclk_fall),
    .fs_s(fs_s), .delayed(delayed), .pwr_up(pwr_up),
    .pos(pos), .pos_nxt(pos_nxt), .start(start), .gate_nxt(gate_nxt)
  );

  pcm_slot_shifter i_shift (
    .clk(clk), .rst(rst), .mclk_rise(mclk_rise), .mclk_fall(mclk_fall),
    .dr_s(dr_s), .reverse(reverse), .comp(cfg_comp), .fmt2(cfg_fmt2),
    .b2(cfg_b2), .en(cfg_en), .pwr_up(pwr_up), .pos(pos), .pos_nxt(pos_nxt),
    .start(start), .gate_nxt(gate_nxt), .tx_pcm(tx_pcm), .inj_data(inj_data),
    .inj_load(inj_load), .dx_d(dx_d), .dx_oe(dx_oe), .rx_pcm(rx_pcm),
    .rx_valid(rx_valid)
  );
endmodule

// File: tb/test_pcm_slot_port.sv
module test_pcm_slot_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, mclk = 1'b0, fs = 1'b0, dr = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_fmt2 = 1'b0, cfg_b2 = 1'b0, cfg_comp = 1'b1, cfg_en = 1'b1;
  logic        pwr_up = 1'b0, inj_load = 1'b0;
  logic [13:0] tx_pcm = '0;
  logic [7:0]  inj_data = '0;
  logic        dx_d, dx_oe, rx_valid;
  logic [13:0] rx_pcm;

  pcm_slot_port i_pcm_slot_port (
    .clk(clk), .rst(rst), .mclk(mclk), .fs(fs), .dr(dr), .cfg_mode(cfg_mode),
    .cfg_fmt2(cfg_fmt2), .cfg_b2(cfg_b2), .cfg_comp(cfg_comp), .cfg_en(cfg_en),
    .pwr_up(pwr_up), .tx_pcm(tx_pcm), .inj_data(inj_data), .inj_load(inj_load),
    .dx_d(dx_d), .dx_oe(dx_oe), .rx_pcm(rx_pcm), .rx_valid(rx_valid)
  );

  int n_run = 0, n_fail = 0, rxv_cnt = 0;
  logic [23:0] oe_seen, dx_seen;

  always @(negedge clk) if (rx_valid === 1'b1) rxv_cnt++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_oe(input int lo, input int len, input bit drive);
    logic [23:0] v = '0;
    for (int p = 0; p < 24; p++) v[p] = drive && p >= lo && p < lo + len;
    return v;
  endfunction

  function automatic logic [23:0] exp_dx(input int lo, input int len, input logic [15:0] w, input bit drive);
    logic [23:0] v = '0;
    for (int p = 0; p < 24; p++)
      if (drive && p >= lo && p < lo + len) v[p] = w[15 - (p - lo)];
    return v;
  endfunction

  function automatic logic [13:0] exp_rx(input logic [23:0] drp, input int lo, input int len, input bit comp);
    logic [15:0] v = '0;
    for (int i = 0; i < len; i++) v = {v[14:0], drp[lo + i]};
    return comp ? {6'b0, v[7:0]} : v[15:2];
  endfunction

  // one lead bit period, then 24 bit periods of the frame
  task automatic run_frame(input logic [1:0] mode, input int fs_len, input logic [23:0] drp, input bit hold_fs);
    mclk = 1'b1; if (!hold_fs) fs = 1'b0;
    wait_n(8);
    mclk = 1'b0; if (mode[1]) fs = 1'b1;
    wait_n(8);
    for (int p = 0; p < 24; p++) begin
      mclk = 1'b1;
      if (!mode[1] && p == 0) fs = 1'b1;
      if (p == fs_len) fs = 1'b0;
      if (mode != 2'b01) dr = drp[p];
      wait_n(8);
      mclk = 1'b0;
      if (mode == 2'b01) dr = drp[p];
      wait_n(6);
      oe_seen[p] = dx_oe;
      dx_seen[p] = dx_d;
      wait_n(2);
    end
  endtask

  task automatic frame_check(input string tag, input int lo, input int len, input logic [15:0] w,
                             input bit drive, input int nvalid, input logic [13:0] rx_exp,
                             input logic [23:0] drp, input int fs_len, input bit hold_fs);
    rxv_cnt = 0;
    run_frame(cfg_mode, fs_len, drp, hold_fs);
    chk({tag, " dx_oe"}, 32'(oe_seen), 32'(exp_oe(lo, len, drive)));
    chk({tag, " dx_d"}, 32'(dx_seen), 32'(exp_dx(lo, len, w, drive)));
    chk({tag, " rx_valid count"}, 32'(rxv_cnt), 32'(nvalid));
    chk({tag, " rx_pcm"}, 32'(rx_pcm), 32'(rx_exp));
  endtask

  task automatic t_reset;
    rst = 1'b1; wait_n(5);
    chk("R1 dx_oe in reset", 32'(dx_oe), 0);
    chk("R1 rx_valid in reset", 32'(rx_valid), 0);
    rst = 1'b0; wait_n(1);
    chk("R1 rx_pcm after reset", 32'(rx_pcm), 0);
    chk("R1 dx_oe after reset", 32'(dx_oe), 0);
  endtask

  task automatic t_power;
    logic [23:0] p1 = 24'h5C_E9_B3, p2 = 24'h0F_36_A1;
    cfg_mode = 2'b00; cfg_comp = 1'b1; cfg_b2 = 1'b0; cfg_fmt2 = 1'b0; cfg_en = 1'b1;
    tx_pcm = 14'h00A5; pwr_up = 1'b1; wait_n(4);
    frame_check("R8 first frame gated", 0, 8, 16'hA500, 0, 1, exp_rx(p1, 0, 8, 1), p1, 1, 0);
    frame_check("R2 R8 second frame b1", 0, 8, 16'hA500, 1, 1, exp_rx(p2, 0, 8, 1), p2, 1, 0);
  endtask

  task automatic t_b2_fmt1;
    logic [23:0] p = 24'h3A_C5_71;
    cfg_b2 = 1'b1; cfg_fmt2 = 1'b0; tx_pcm = 14'h003C;
    frame_check("R5 b2 fmt1", 8, 8, 16'h3C00, 1, 1, exp_rx(p, 8, 8, 1), p, 1, 0);
  endtask

  task automatic t_b2_fmt2;
    logic [23:0] p = 24'h2B_D4_96;
    cfg_b2 = 1'b1; cfg_fmt2 = 1'b1; tx_pcm = 14'h00C3;
    frame_check("R5 b2 fmt2 gap", 10, 8, 16'hC300, 1, 1, exp_rx(p, 10, 8, 1), p, 1, 0);
  endtask

  task automatic t_reverse;
    logic [23:0] p = 24'h81_7E_4D;
    cfg_mode = 2'b01; cfg_b2 = 1'b0; tx_pcm = 14'h0096;
    frame_check("R3 reverse edges", 0, 8, 16'h9600, 1, 1, exp_rx(p, 0, 8, 1), p, 1, 0);
  endtask

  task automatic t_delayed;
    logic [23:0] p = 24'hE4_1B_C8;
    cfg_mode = 2'b10; cfg_b2 = 1'b1; cfg_fmt2 = 1'b1; tx_pcm = 14'h0069;
    frame_check("R4 delayed b2", 10, 8, 16'h6900, 1, 1, exp_rx(p, 10, 8, 1), p, 1, 0);
  endtask

  task automatic t_linear;
    logic [23:0] p = 24'h6D_92_E7;
    cfg_mode = 2'b00; cfg_comp = 1'b0; cfg_b2 = 1'b1; cfg_fmt2 = 1'b1; tx_pcm = 14'h2D6B;
    frame_check("R6 linear slot", 0, 16, {14'h2D6B, 2'b00}, 1, 1, exp_rx(p, 0, 16, 0), p, 1, 0);
  endtask

  task automatic t_disabled;
    logic [23:0] p = 24'hFF_00_FF;
    logic [13:0] prev = rx_pcm;
    cfg_comp = 1'b1; cfg_b2 = 1'b0; cfg_fmt2 = 1'b0; cfg_en = 1'b0;
    frame_check("R7 enable off", 0, 8, 16'h0000, 0, 0, prev, p, 1, 0);
    cfg_en = 1'b1;
  endtask

  task automatic t_inject;
    logic [23:0] p = 24'h13_57_9B;
    tx_pcm = 14'h00A5; inj_data = 8'h5A;
    inj_load = 1'b1; wait_n(1); inj_load = 1'b0;
    frame_check("R9 injected frame", 0, 8, 16'h5A00, 1, 1, exp_rx(p, 0, 8, 1), p, 1, 0);
    frame_check("R9 following frame", 0, 8, 16'hA500, 1, 1, exp_rx(p, 0, 8, 1), p, 1, 0);
  endtask

  task automatic t_fs_hold;
    logic [23:0] p = 24'hC6_39_D2, q = 24'h55_AA_55;
    tx_pcm = 14'h007E;
    frame_check("R11 long sync frame", 0, 8, 16'h7E00, 1, 1, exp_rx(p, 0, 8, 1), p, 24, 0);
    frame_check("R11 sync held, no restart", 0, 8, 16'h0000, 0, 0, exp_rx(p, 0, 8, 1), q, 24, 1);
  endtask

  task automatic t_powerdown;
    logic [23:0] p = 24'h0A_F0_5F;
    logic [13:0] prev = rx_pcm;
    pwr_up = 1'b0; wait_n(2);
    chk("R12 dx_oe after power down", 32'(dx_oe), 0);
    frame_check("R12 powered down frame", 0, 8, 16'h0000, 0, 0, prev, p, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(2);
    t_reset();
    t_power();
    t_b2_fmt1();
    t_b2_fmt2();
    t_reverse();
    t_delayed();
    t_linear();
    t_disabled();
    t_inject();
    t_fs_hold();
    t_powerdown();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule